// File: doc/BRIEF.md
# Oscillator Wake-Up Timer

This block keeps the rest of the chip waiting after a start event until an external crystal or resonator has had time to settle. Three start sources feed it: power-on reset, an external reset and the exit from halt. On any of them it takes a snapshot of an 8-bit delay setting, clears its counters and drops `ready_o`. It then counts input clock cycles through a fixed power-of-two prescaler, and raises `ready_o` once the programmed number of prescaler periods has passed. With the default prescaler of 4096 clocks, the wait is 4096 × (setting + 1) clock periods.

When the internal oscillator is the clock source, no settling time is needed. In that case the counted wait is skipped and `ready_o` comes up one clock after the start event. The setting 255 is not allowed. The block treats it as 254 and raises a sticky flag that software clears with a one-cycle pulse. A new start event during a wait discards that wait and starts over.

Top module: `osc_wake_timer`

## Requirements
- R1: Taking the edge that samples a start event as edge 0, and with the counted wait in use, `ready_o` is low after edge 2^PRESC_W × (D + 1) − 1 and high after edge 2^PRESC_W × (D + 1). D is the delay setting captured at edge 0, and PRESC_W defaults to 12, which gives 4096.
- R2: While `arst_ni` is low, `ready_o` and `ill_cfg_o` are low. Both stay low after reset is released until the first start event.
- R3: A high level on `por_evt_i`, `ext_rst_evt_i` or `halt_wake_evt_i` at a rising edge starts the sequence, and `ready_o` is low right after that edge.
- R4: If `int_clk_sel_i` is high at the edge that samples the start event, `ready_o` is high after the following edge. There is no counted wait.
- R5: `dly_cfg_i` and `int_clk_sel_i` are sampled only at the start event. Later changes do not alter the running wait.
- R6: A setting of 255 (all ones) at the start event is treated as 254, which gives a wait of 2^PRESC_W × 255 clocks.
- R7: `ill_cfg_o` goes high after the edge that samples a start event with a setting of 255. It then stays high until an edge that sees `ill_clr_i` high. If a forbidden start event and a clear arrive at the same edge, the flag is set.
- R8: A start event during a running wait clears the count, and the timing of R1 or R4 then applies from the new event.
- R9: Once `ready_o` is high, it stays high until the next start event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock being counted |
| arst_ni | input | 1 | Asynchronous active-low reset, released after SYNC_STAGES edges |
| dly_cfg_i | input | 8 | Delay setting D, in units of 2^PRESC_W clocks minus one |
| int_clk_sel_i | input | 1 | High when the internal oscillator drives the clock |
| por_evt_i | input | 1 | Power-on reset start pulse |
| ext_rst_evt_i | input | 1 | External reset start pulse |
| halt_wake_evt_i | input | 1 | Halt exit start pulse |
| ill_clr_i | input | 1 | Clears the forbidden-setting flag |
| ready_o | output | 1 | Oscillator settled; the chip may run |
| ill_cfg_o | output | 1 | Sticky flag: a setting of 255 was captured |

## Verification
The bench counts every result from the rising edge that samples the start pulse. `ready_o` must be low right after that edge and still low after edge N − 1, where N is 2^PRESC_W × (D + 1), or N is 1 when the internal clock is selected. It must be high after edge N. The flag must follow one edge after the start event or after the clear pulse. Inputs are driven and outputs sampled on falling edges, so each check falls in the middle of the cycle it is due in. The bench uses a prescaler width of 4 so that the wait for a setting of 255 fits in the run.

// File: rtl/osc_wake_pkg.sv
package osc_wake_pkg;

  localparam int unsigned DLY_W = 8;

  localparam logic [DLY_W-1:0] DLY_FORBID = {DLY_W{1'b1}};
  localparam logic [DLY_W-1:0] DLY_CLAMP  = {{(DLY_W-1){1'b1}}, 1'b0};

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COUNT  = 2'd1,
    ST_BYPASS = 2'd2,
    ST_READY  = 2'd3
  } wk_state_e;

endpackage

// File: rtl/osc_wake_rstsync.sv
module osc_wake_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/osc_wake_evt.sv
module osc_wake_evt
  import osc_wake_pkg::*;
#(
  parameter int unsigned NUM_SRC = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_evt_i,
  input  logic [DLY_W-1:0]   dly_i,
  input  logic               ill_clr_i,
  output logic               start_o,
  output logic [DLY_W-1:0]   lim_o,
  output logic               ill_o
);

  // merge start sources
  logic [NUM_SRC:0] any_chain;
  assign any_chain[0] = 1'b0;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign any_chain[g+1] = any_chain[g] | src_evt_i[g];
  end

  assign start_o = any_chain[NUM_SRC];

  // setting capture with clamp of the forbidden value
  logic             forbid;
  logic [DLY_W-1:0] lim_q, lim_d;
  logic             ill_q, ill_d;
  logic             lim_en;

  assign forbid = (dly_i == DLY_FORBID);
  assign lim_en = start_o;

  always_comb begin
    lim_d = lim_q;
    if (lim_en) begin
      lim_d = forbid ? DLY_CLAMP : dly_i;
    end
  end

  always_comb begin
    ill_d = ill_q;
    if (ill_clr_i) begin
      ill_d = 1'b0;
    end
    if (start_o && forbid) begin
      ill_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q <= '0;
      ill_q <= 1'b0;
    end else begin
      lim_q <= lim_d;
      ill_q <= ill_d;
    end
  end

  assign lim_o = lim_q;
  assign ill_o = ill_q;

  AST_CLAMP_FORBID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && dly_i == DLY_FORBID) |=> (lim_o == DLY_CLAMP)); // R6
  AST_LIMIT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_o |=> $stable(lim_o)); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ill_o && !ill_clr_i) |=> ill_o); // R7
  AST_FLAG_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && dly_i == DLY_FORBID && ill_clr_i) |=> ill_o); // R7

endmodule

// File: rtl/osc_wake_cnt.sv
module osc_wake_cnt
  import osc_wake_pkg::*;
#(
  parameter int unsigned PRESC_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [DLY_W-1:0] lim_i,
  output logic             term_o
);

  localparam logic [PRESC_W-1:0] PRESC_TOP = {PRESC_W{1'b1}};

  logic [PRESC_W-1:0] presc_q, presc_d;
  logic [DLY_W-1:0]   outer_q, outer_d;
  logic               wrap;

  assign wrap   = (presc_q == PRESC_TOP);
  assign term_o = en_i && wrap && (outer_q == lim_i);

  always_comb begin
    presc_d = presc_q;
    outer_d = outer_q;
    if (clr_i || term_o) begin
      presc_d = '0;
      outer_d = '0;
    end else if (en_i) begin
      presc_d = presc_q + 1'b1;
      if (wrap) begin
        outer_d = outer_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      outer_q <= '0;
    end else begin
      presc_q <= presc_d;
      outer_q <= outer_d;
    end
  end

  AST_OUTER_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (outer_q <= lim_i)); // R1
  AST_PRESC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(presc_q)); // R1

endmodule

// File: rtl/osc_wake_fsm.sv
module osc_wake_fsm
  import osc_wake_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic int_clk_i,
  input  logic term_i,
  output logic cnt_en_o,
  output logic cnt_clr_o,
  output logic ready_o
);

  wk_state_e state_q, state_d;
  logic      ready_q, ready_d;

  always_comb begin
    state_d = state_q;
    if (start_i) begin
      state_d = int_clk_i ? ST_BYPASS : ST_COUNT;
    end else begin
      case (state_q)
        ST_IDLE:   state_d = ST_IDLE;
        ST_COUNT:  state_d = term_i ? ST_READY : ST_COUNT;
        ST_BYPASS: state_d = ST_READY;
        ST_READY:  state_d = ST_READY;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  assign ready_d = (state_d == ST_READY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= ready_d;
    end
  end

  assign cnt_en_o  = (state_q == ST_COUNT);
  assign cnt_clr_o = start_i;
  assign ready_o   = ready_q;

  AST_START_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !ready_o); // R3
  AST_BYPASS_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && int_clk_i) ##1 !start_i |=> ready_o); // R4
  AST_READY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i) |=> ready_o); // R9
  AST_READY_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ($past(term_i) || $past(state_q == ST_BYPASS))); // R1

endmodule

// File: rtl/osc_wake_timer.sv
module osc_wake_timer
  import osc_wake_pkg::*;
#(
  parameter int unsigned PRESC_W     = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             arst_ni,
  input  logic [DLY_W-1:0] dly_cfg_i,
  input  logic             int_clk_sel_i,
  input  logic             por_evt_i,
  input  logic             ext_rst_evt_i,
  input  logic             halt_wake_evt_i,
  input  logic             ill_clr_i,
  output logic             ready_o,
  output logic             ill_cfg_o
);

  localparam int unsigned NUM_SRC = 3;

  logic               rst_n;
  logic [NUM_SRC-1:0] src_evt;
  logic               start;
  logic [DLY_W-1:0]   lim;
  logic               cnt_en;
  logic               cnt_clr;
  logic               term;

  assign src_evt = {halt_wake_evt_i, ext_rst_evt_i, por_evt_i};

  osc_wake_rstsync #(.STAGES(SYNC_STAGES)) u_rstsync (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .rst_no  (rst_n)
  );

  osc_wake_evt #(.NUM_SRC(NUM_SRC)) u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .src_evt_i (src_evt),
    .dly_i     (dly_cfg_i),
    .ill_clr_i (ill_clr_i),
    .start_o   (start),
    .lim_o     (lim),
    .ill_o     (ill_cfg_o)
  );

  osc_wake_cnt #(.PRESC_W(PRESC_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .clr_i  (cnt_clr),
    .en_i   (cnt_en),
    .lim_i  (lim),
    .term_o (term)
  );

  osc_wake_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .start_i   (start),
    .int_clk_i (int_clk_sel_i),
    .term_i    (term),
    .cnt_en_o  (cnt_en),
    .cnt_clr_o (cnt_clr),
    .ready_o   (ready_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!ready_o && !start && !cnt_en && !$past(start)) |=> !ready_o || $past(term)); // R2

endmodule

// File: tb/test_osc_wake_timer.sv
module test_osc_wake_timer;

  localparam int PW = 4;
  localparam int P  = 1 << PW;

  logic       clk = 1'b0;
  logic       arst_n;
  logic [7:0] dly;
  logic       isel, por, ext, hwk, clr;
  logic       ready, ill;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;
  bit  mflag  = 0;

  always #5 clk = ~clk;

  osc_wake_timer #(.PRESC_W(PW), .SYNC_STAGES(2)) i_osc_wake_timer (
    .clk_i           (clk),
    .arst_ni         (arst_n),
    .dly_cfg_i       (dly),
    .int_clk_sel_i   (isel),
    .por_evt_i       (por),
    .ext_rst_evt_i   (ext),
    .halt_wake_evt_i (hwk),
    .ill_clr_i       (clr),
    .ready_o         (ready),
    .ill_cfg_o       (ill)
  );

  function automatic int exp_wait(int d, bit sel);
    int e;
    if (sel) return 1;
    e = (d == 255) ? 254 : d;
    return P * (e + 1);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic fire(int src);
    @(negedge clk);
    por = (src == 0);
    ext = (src == 1);
    hwk = (src == 2);
    @(negedge clk);
    por = 1'b0; ext = 1'b0; hwk = 1'b0;
  endtask

  // event, then check ready low at edge N-1 and high at edge N
  task automatic run(int d, bit sel, int src, bit scramble, string req);
    int n;
    dly  = d[7:0];
    isel = sel;
    n = exp_wait(d, sel);
    fire(src);
    if (d == 255) mflag = 1;
    chk("R3", int'(ready), 0);
    chk("R7", int'(ill), int'(mflag));
    if (scramble) begin
      dly  = 8'($urandom_range(0, 255));
      isel = 1'($urandom_range(0, 1));
    end
    repeat (n - 1) @(negedge clk);
    if (n > 1) chk(req, int'(ready), 0);
    @(negedge clk);
    chk(req, int'(ready), 1);
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    mflag = 0;
    chk("R7", int'(ill), 0);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_up();
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0A11);
    arst_n = 1'b0;
    dly = 8'd0; isel = 1'b0; por = 1'b0; ext = 1'b0; hwk = 1'b0; clr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2", int'(ready), 0);
    chk("R2", int'(ill), 0);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
    repeat (50) @(negedge clk);
    chk("R2", int'(ready), 0);
    chk("R2", int'(ill), 0);

    // directed waits from each source
    run(0, 1'b0, 0, 1'b0, "R1");
    run(1, 1'b0, 1, 1'b0, "R1");
    run(0, 1'b1, 2, 1'b0, "R4");
    run(3, 1'b0, 2, 1'b1, "R5");
    run(2, 1'b1, 0, 1'b1, "R5");
    repeat (40) @(negedge clk);
    chk("R9", int'(ready), 1);

    // forbidden setting
    run(255, 1'b0, 1, 1'b0, "R6");
    repeat (20) @(negedge clk);
    chk("R7", int'(ill), 1);
    pulse_clr();
    dly = 8'hFF;
    clr = 1'b1;
    fire(0);
    clr = 1'b0;
    mflag = 1;
    chk("R7", int'(ill), 1);
    pulse_clr();

    // restart during a running wait
    dly = 8'd5; isel = 1'b0;
    fire(1);
    repeat (40) @(negedge clk);
    chk("R8", int'(ready), 0);
    run(2, 1'b0, 0, 1'b0, "R8");
    dly = 8'd9;
    fire(2);
    repeat (7) @(negedge clk);
    run(0, 1'b1, 1, 1'b0, "R8");

    // random trials
    for (int t = 0; t < 24; t++) begin
      int d;
      bit s;
      d = ($urandom_range(0, 5) == 0) ? 255 : $urandom_range(0, 20);
      s = ($urandom_range(0, 3) == 0);
      run(d, s, $urandom_range(0, 2), 1'b1, s ? "R4" : (d == 255 ? "R6" : "R1"));
      chk("R7", int'(ill), int'(mflag));
      if ($urandom_range(0, 1) == 1) pulse_clr();
      repeat ($urandom_range(0, 10)) @(negedge clk);
      chk("R9", int'(ready), 1);
    end

    done = 1;
    finish_up();
  end

endmodule